// File: doc/BRIEF.md
# Mask-Steered Partitioned Data Cache

This block is a small write-back data cache. Its ways are organised as separately enabled partitions, four by default and two or eight by parameter. Every load or store carries a per-partition enable vector and a restrict flag. With the flag set, only the partitions named in the vector have their tag and data arrays read. With the flag clear, every partition is read. In both cases a miss may place the new line only in a partition that the vector names. Software that knows which references share a working set can therefore keep them apart, and it can cut the number of arrays switched on per access.

The hitting partition's line passes through a one-hot AND-OR multiplexer, and the addressed 32-bit word is returned. A miss picks the least recently used permitted partition, with invalid partitions preferred. A dirty victim is written back first. The new line is then fetched over a whole-line request/acknowledge memory port, and any stale copy of it in another partition is invalidated. A free-running counter accumulates the number of partitions read during each lookup, so energy savings can be measured against a read-all-ways baseline.

The controller is a five-state machine:

- IDLE accepts a request and moves to PROBE.
- PROBE moves to DONE on a hit. On a miss it moves to EVICT if the victim is valid and dirty, and to FILL otherwise.
- EVICT moves to FILL on acknowledge.
- FILL moves to DONE on acknowledge.
- DONE returns to IDLE.

Top module: `pcache_top`

## Requirements
- R1: A request accepted in IDLE that hits raises resp_valid exactly two clock edges after the accepting edge, for one cycle, with the addressed word on resp_rdata.
- R2: act_count rises once per lookup. With req_restrict=1 it rises by the number of set bits in req_mask. With req_restrict=0 it rises by the partition count.
- R3: An all-zero req_mask is treated as all ones, both for the partitions read and for the partitions eligible for replacement.
- R4: A restricted lookup that misses in its partitions fetches the line from memory even if another partition holds it. When the line is installed, that other copy is invalidated, so a later restricted lookup of the old partition misses.
- R5: On a miss the new line is placed only in a partition whose mask bit is set, whether req_restrict is 1 or 0.
- R6: The victim is the lowest-numbered invalid permitted partition if one exists. Otherwise it is the least recently used permitted partition of the set. Every hit and every fill marks its partition most recently used.
- R7: A dirty victim is written to memory (mem_we=1, its line address) before the refill read is requested. A clean victim causes no memory write.
- R8: Stores allocate on a miss and merge the store word into the fetched line. A store that hits updates the line without memory traffic, and the updated word is returned by later loads and by write-back.
- R9: req_ready is low from the accepting edge until the request completes. Once raised, mem_req stays high, with a stable address and direction, until mem_ack.
- R10: After reset, req_ready=1, resp_valid=0, mem_req=0 and act_count=0.
- R11: Address bits [4:2] select the word within the 32-byte line. Bits [7:5] select the set and bits [31:8] form the tag (default parameters).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle, request taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_W | Store data |
| req_mask | input | NUM_PARTS | One enable bit per partition |
| req_restrict | input | 1 | 1 = read only masked partitions |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | WORD_W | Load data (store data for stores) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | LINE_BYTES*8 | Line being written back |
| mem_ack | input | 1 | Transfer complete, refill data valid |
| mem_rdata | input | LINE_BYTES*8 | Refill line |
| act_count | output | CNT_W | Running count of partition reads |

## Verification
A wrong valid, tag or LRU rank usually stays hidden until the same set is touched again. It then shows up as an unexpected memory read on an access that should hit, or as a hit whose latency or data is wrong. The bench therefore probes single partitions with one-bit restricted masks right after each fill, so a misplaced line appears within one request. A lost dirty bit shows up at the next eviction of that set, as a missing write on the memory port or as stale data on the reload that follows.

// File: rtl/pcache_pkg.sv
package pcache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_EVICT,
        ST_FILL,
        ST_DONE
    } pc_state_t;
endpackage

// File: rtl/pcache_part.sv
module pcache_part #(
    parameter int NUM_SETS = 8,
    parameter int TAG_W    = 24,
    parameter int LINE_W   = 256,
    parameter int WORD_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [$clog2(NUM_SETS)-1:0]   set_idx,
    input  logic [TAG_W-1:0]              cmp_tag,
    input  logic                          fill_en,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [LINE_W-1:0]             fill_line,
    input  logic                          fill_dirty,
    input  logic                          st_en,
    input  logic [$clog2(LINE_W/WORD_W)-1:0] st_wsel,
    input  logic [WORD_W-1:0]             st_data,
    input  logic                          inv_en,
    output logic                          valid_o,
    output logic                          dirty_o,
    output logic                          match_o,
    output logic [TAG_W-1:0]              tag_o,
    output logic [LINE_W-1:0]             line_o
);
    logic [TAG_W-1:0]  tag_mem  [NUM_SETS];
    logic [LINE_W-1:0] data_mem [NUM_SETS];
    logic [NUM_SETS-1:0] valid_q;
    logic [NUM_SETS-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[set_idx] <= 1'b1;
                dirty_q[set_idx] <= fill_dirty;
            end else if (inv_en) begin
                valid_q[set_idx] <= 1'b0;
                dirty_q[set_idx] <= 1'b0;
            end else if (st_en) begin
                dirty_q[set_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_mem[set_idx]  <= fill_tag;
            data_mem[set_idx] <= fill_line;
        end else if (st_en) begin
            data_mem[set_idx][st_wsel*WORD_W +: WORD_W] <= st_data;
        end
    end

    // arrays are only read when this partition is enabled
    always_comb begin
        valid_o = rd_en & valid_q[set_idx];
        dirty_o = rd_en & dirty_q[set_idx];
        tag_o   = rd_en ? tag_mem[set_idx] : '0;
        line_o  = rd_en ? data_mem[set_idx] : '0;
        match_o = valid_o && (tag_o == cmp_tag);
    end
endmodule

// File: rtl/pcache_lru.sv
module pcache_lru #(
    parameter int NUM_PARTS = 4,
    parameter int NUM_SETS  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(NUM_SETS)-1:0]   set_idx,
    input  logic [NUM_PARTS-1:0]          allow,
    input  logic [NUM_PARTS-1:0]          valid_vec,
    input  logic                          touch_en,
    input  logic [$clog2(NUM_PARTS)-1:0]  touch_idx,
    output logic [$clog2(NUM_PARTS)-1:0]  victim_o
);
    localparam int PIDX_W = $clog2(NUM_PARTS);

    // rank per partition per set: 0 = most recent, NUM_PARTS-1 = oldest
    logic [PIDX_W-1:0] age_q [NUM_SETS][NUM_PARTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int p = 0; p < NUM_PARTS; p++) begin
                    age_q[s][p] <= PIDX_W'(p);
                end
            end
        end else if (touch_en) begin
            for (int p = 0; p < NUM_PARTS; p++) begin
                if (PIDX_W'(p) == touch_idx) begin
                    age_q[set_idx][p] <= '0;
                end else if (age_q[set_idx][p] < age_q[set_idx][touch_idx]) begin
                    age_q[set_idx][p] <= age_q[set_idx][p] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        logic found_inv;
        logic found_any;
        logic [PIDX_W-1:0] best_age;
        found_inv = 1'b0;
        found_any = 1'b0;
        best_age  = '0;
        victim_o  = '0;
        for (int p = 0; p < NUM_PARTS; p++) begin
            if (allow[p] && !valid_vec[p] && !found_inv) begin
                victim_o  = PIDX_W'(p);
                found_inv = 1'b1;
            end
        end
        if (!found_inv) begin
            for (int p = 0; p < NUM_PARTS; p++) begin
                if (allow[p] && (!found_any || age_q[set_idx][p] > best_age)) begin
                    victim_o  = PIDX_W'(p);
                    best_age  = age_q[set_idx][p];
                    found_any = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcache_sel.sv
module pcache_sel #(
    parameter int N = 4,
    parameter int W = 256
) (
    input  logic [N-1:0] sel,
    input  logic [W-1:0] din [N],
    output logic [W-1:0] dout
);
    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            dout = dout | (din[i] & {W{sel[i]}});
        end
    end
endmodule

// File: rtl/pcache_top.sv
module pcache_top
    import pcache_pkg::*;
#(
    parameter int NUM_PARTS  = 4,
    parameter int NUM_SETS   = 8,
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int CNT_W      = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [WORD_W-1:0]        req_wdata,
    input  logic [NUM_PARTS-1:0]     req_mask,
    input  logic                     req_restrict,
    output logic                     resp_valid,
    output logic [WORD_W-1:0]        resp_rdata,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [LINE_BYTES*8-1:0]  mem_wdata,
    input  logic                     mem_ack,
    input  logic [LINE_BYTES*8-1:0]  mem_rdata,
    output logic [CNT_W-1:0]         act_count
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORDS  = LINE_W / WORD_W;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BSEL_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
    localparam int PIDX_W = $clog2(NUM_PARTS);

    pc_state_t state_q, state_d;

    logic                 q_write;
    logic                 q_restrict;
    logic [TAG_W-1:0]     q_tag;
    logic [SET_W-1:0]     q_set;
    logic [WSEL_W-1:0]    q_wsel;
    logic [WORD_W-1:0]    q_wdata;
    logic [NUM_PARTS-1:0] q_allow;
    logic [PIDX_W-1:0]    vic_q;
    logic [WORD_W-1:0]    rdata_q;
    logic [CNT_W-1:0]     act_q;

    logic [NUM_PARTS-1:0] probe_en, rd_en, vic_oh;
    logic [NUM_PARTS-1:0] p_valid, p_dirty, p_match, hit_vec;
    logic [NUM_PARTS-1:0] fill_vec, inv_vec, st_vec, line_sel;
    logic [TAG_W-1:0]     p_tag  [NUM_PARTS];
    logic [LINE_W-1:0]    p_line [NUM_PARTS];
    logic [LINE_W-1:0]    sel_line, fill_line;
    logic [TAG_W-1:0]     vic_tag;
    logic [PIDX_W-1:0]    hit_idx, lru_vic, touch_idx;
    logic [PIDX_W:0]      en_cnt;
    logic                 hit, fill_ok, touch_en;
    logic [WORD_W-1:0]    hit_word, mem_word;

    assign probe_en = q_restrict ? q_allow : '1;
    assign vic_oh   = NUM_PARTS'(1) << vic_q;
    assign hit_vec  = (state_q == ST_PROBE) ? p_match : '0;
    assign hit      = |hit_vec;
    assign fill_ok  = (state_q == ST_FILL) && mem_ack;

    always_comb begin
        hit_idx = '0;
        en_cnt  = '0;
        for (int i = 0; i < NUM_PARTS; i++) begin
            if (hit_vec[i]) hit_idx = PIDX_W'(i);
            en_cnt = en_cnt + (PIDX_W+1)'(probe_en[i]);
        end
    end

    // per-partition write strobes
    always_comb begin
        for (int i = 0; i < NUM_PARTS; i++) begin
            fill_vec[i] = fill_ok && (vic_q == PIDX_W'(i));
            inv_vec[i]  = fill_ok && p_match[i] && (vic_q != PIDX_W'(i));
            st_vec[i]   = (state_q == ST_PROBE) && q_write && hit_vec[i];
        end
    end

    always_comb begin
        fill_line = mem_rdata;
        if (q_write) fill_line[q_wsel*WORD_W +: WORD_W] = q_wdata;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_PARTS; g++) begin : g_part
            pcache_part #(
                .NUM_SETS(NUM_SETS), .TAG_W(TAG_W),
                .LINE_W(LINE_W), .WORD_W(WORD_W)
            ) u_part (
                .clk(clk), .rst_n(rst_n),
                .rd_en(rd_en[g]), .set_idx(q_set), .cmp_tag(q_tag),
                .fill_en(fill_vec[g]), .fill_tag(q_tag),
                .fill_line(fill_line), .fill_dirty(q_write),
                .st_en(st_vec[g]), .st_wsel(q_wsel), .st_data(q_wdata),
                .inv_en(inv_vec[g]),
                .valid_o(p_valid[g]), .dirty_o(p_dirty[g]),
                .match_o(p_match[g]), .tag_o(p_tag[g]), .line_o(p_line[g])
            );
        end
    endgenerate

    assign line_sel = (state_q == ST_EVICT) ? vic_oh : hit_vec;

    pcache_sel #(.N(NUM_PARTS), .W(LINE_W)) u_line_mux (
        .sel(line_sel), .din(p_line), .dout(sel_line)
    );

    pcache_sel #(.N(NUM_PARTS), .W(TAG_W)) u_tag_mux (
        .sel(vic_oh), .din(p_tag), .dout(vic_tag)
    );

    assign touch_en  = ((state_q == ST_PROBE) && hit) || fill_ok;
    assign touch_idx = (state_q == ST_PROBE) ? hit_idx : vic_q;

    pcache_lru #(.NUM_PARTS(NUM_PARTS), .NUM_SETS(NUM_SETS)) u_lru (
        .clk(clk), .rst_n(rst_n), .set_idx(q_set),
        .allow(q_allow), .valid_vec(p_valid),
        .touch_en(touch_en), .touch_idx(touch_idx),
        .victim_o(lru_vic)
    );

    assign hit_word = sel_line[q_wsel*WORD_W +: WORD_W];
    assign mem_word = mem_rdata[q_wsel*WORD_W +: WORD_W];

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_PROBE;
            ST_PROBE: begin
                if (hit)                                   state_d = ST_DONE;
                else if (p_valid[lru_vic] && p_dirty[lru_vic]) state_d = ST_EVICT;
                else                                       state_d = ST_FILL;
            end
            ST_EVICT: if (mem_ack) state_d = ST_FILL;
            ST_FILL:  if (mem_ack) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {q_tag, q_set, OFF_W'(0)};
        rd_en      = '0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_PROBE: rd_en = probe_en;
            ST_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {vic_tag, q_set, OFF_W'(0)};
                rd_en    = vic_oh;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                rd_en   = '1;
            end
            ST_DONE:  resp_valid = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    assign mem_wdata  = sel_line;
    assign resp_rdata = rdata_q;
    assign act_count  = act_q;

    // request and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_write    <= 1'b0;
            q_restrict <= 1'b0;
            q_tag      <= '0;
            q_set      <= '0;
            q_wsel     <= '0;
            q_wdata    <= '0;
            q_allow    <= '1;
            vic_q      <= '0;
            rdata_q    <= '0;
            act_q      <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                q_write    <= req_write;
                q_restrict <= req_restrict;
                q_tag      <= req_addr[ADDR_W-1 -: TAG_W];
                q_set      <= req_addr[OFF_W +: SET_W];
                q_wsel     <= req_addr[BSEL_W +: WSEL_W];
                q_wdata    <= req_wdata;
                q_allow    <= (req_mask == '0) ? '1 : req_mask;
            end
            if (state_q == ST_PROBE) begin
                act_q <= act_q + CNT_W'(en_cnt);
                if (hit) rdata_q <= q_write ? q_wdata : hit_word;
                else     vic_q   <= lru_vic;
            end
            if (fill_ok) rdata_q <= q_write ? q_wdata : mem_word;
        end
    end
endmodule

// File: rtl/pcache_chk.sv
module pcache_chk #(
    parameter int NUM_PARTS = 4,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 resp_valid,
    input logic                 mem_req,
    input logic                 mem_we,
    input logic                 mem_ack,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic [CNT_W-1:0]     act_count,
    input logic [NUM_PARTS-1:0] hit_vec,
    input logic [NUM_PARTS-1:0] fill_vec,
    input logic [NUM_PARTS-1:0] q_allow
);
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r1_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r4_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    a_r5_fill_in_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (|fill_vec) |-> ($onehot(fill_vec) && ((fill_vec & ~q_allow) == '0)));

    a_r2_act_step: assert property (@(posedge clk) disable iff (!rst_n)
        (act_count - $past(act_count)) <= CNT_W'(NUM_PARTS));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !resp_valid));
endmodule

bind pcache_top pcache_chk #(
    .NUM_PARTS(NUM_PARTS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .act_count(act_count),
    .hit_vec(hit_vec), .fill_vec(fill_vec), .q_allow(q_allow)
);

// File: tb/sim_pcache_top.sv
`timescale 1ns/1ps
module sim_pcache_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_ready, req_write, req_restrict;
    logic [31:0]  req_addr, req_wdata;
    logic [3:0]   req_mask;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic         mem_req, mem_we, mem_ack;
    logic [31:0]  mem_addr;
    logic [255:0] mem_wdata, mem_rdata;
    logic [31:0]  act_count;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pcache_top u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_restrict(req_restrict), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .act_count(act_count)
    );

    // backing memory model
    logic [255:0] bk [logic [31:0]];
    int           n_rd = 0;
    int           n_wr = 0;
    logic [31:0]  log_addr [64];
    bit           log_we   [64];
    int           log_n = 0;
    logic [255:0] last_wr_data;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [255:0] line_of(input logic [31:0] a);
        logic [255:0] l;
        if (bk.exists(a)) return bk[a];
        for (int i = 0; i < 8; i++) l[i*32 +: 32] = pat(a + 32'(i*4));
        return l;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder: ack two cycles after request is first seen
    initial begin
        int lat;
        bit held;
        lat = 0;
        held = 1'b0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (!rst_n) begin
                lat = 0;
                held = 1'b0;
            end else if (mem_req) begin
                if (lat == 0) held = 1'b1;
                if (lat == 2) begin
                    check("R9", "mem_req held until ack", 32'(held), 32'd1);
                    mem_ack = 1'b1;
                    lat = 0;
                    if (log_n < 64) begin
                        log_addr[log_n] = mem_addr;
                        log_we[log_n]   = mem_we;
                        log_n++;
                    end
                    if (mem_we) begin
                        bk[mem_addr] = mem_wdata;
                        last_wr_data = mem_wdata;
                        n_wr++;
                    end else begin
                        mem_rdata = line_of(mem_addr);
                        n_rd++;
                    end
                end else begin
                    lat++;
                end
            end else if (lat != 0) begin
                held = 1'b0;
                check("R9", "mem_req dropped before ack", 32'd0, 32'd1);
            end
        end
    end

    // one request, results returned for the scenario to check
    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                          input logic [3:0] m, input bit r,
                          output logic [31:0] rd, output int lat,
                          output int rds, output int wrs, output logic [31:0] acts);
        int r0, w0;
        logic [31:0] c0;
        @(negedge clk);
        r0 = n_rd;
        w0 = n_wr;
        c0 = act_count;
        check("R9", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        req_mask = m; req_restrict = r;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "ready low after accept", 32'(req_ready), 32'd0);
        lat = 1;
        while (!resp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        if (lat >= 200) check("R9", "request timeout", 32'd0, 32'd1);
        rd   = resp_rdata;
        rds  = n_rd - r0;
        wrs  = n_wr - w0;
        acts = act_count - c0;
    endtask

    task automatic t_reset();
        check("R10", "req_ready", 32'(req_ready), 32'd1);
        check("R10", "resp_valid", 32'(resp_valid), 32'd0);
        check("R10", "mem_req", 32'(mem_req), 32'd0);
        check("R10", "act_count", act_count, 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] rd, ac; int lat, rds, wrs;
        access(0, 32'h10C, 0, 4'b0001, 1, rd, lat, rds, wrs, ac);
        check("R11", "miss data word 3", rd, pat(32'h10C));
        check("R4", "first access reads memory", 32'(rds), 32'd1);
        check("R2", "restricted count 1", ac, 32'd1);
        access(0, 32'h110, 0, 4'b0001, 1, rd, lat, rds, wrs, ac);
        check("R1", "hit latency", 32'(lat), 32'd2);
        check("R1", "hit no memory read", 32'(rds), 32'd0);
        check("R11", "hit data word 4", rd, pat(32'h110));
        access(0, 32'h11C, 0, 4'b0001, 0, rd, lat, rds, wrs, ac);
        check("R2", "unrestricted count 4", ac, 32'd4);
        check("R11", "hit data word 7", rd, pat(32'h11C));
    endtask

    task automatic t_zero_mask();
        logic [31:0] rd, ac; int lat, rds, wrs;
        access(0, 32'h104, 0, 4'b0000, 1, rd, lat, rds, wrs, ac);
        check("R3", "zero mask count 4", ac, 32'd4);
        check("R3", "zero mask hits", 32'(rds), 32'd0);
        check("R3", "zero mask data", rd, pat(32'h104));
    endtask

    task automatic t_restrict_miss();
        logic [31:0] rd, ac; int lat, rds, wrs;
        access(0, 32'h100, 0, 4'b0110, 1, rd, lat, rds, wrs, ac);
        check("R2", "two-bit mask count", ac, 32'd2);
        check("R4", "unmasked copy not used", 32'(rds), 32'd1);
        access(0, 32'h100, 0, 4'b0010, 1, rd, lat, rds, wrs, ac);
        check("R5", "placed in partition 1", 32'(rds), 32'd0);
        access(0, 32'h100, 0, 4'b0001, 1, rd, lat, rds, wrs, ac);
        check("R4", "stale copy invalidated", 32'(rds), 32'd1);
        check("R4", "refetched data", rd, pat(32'h100));
    endtask

    task automatic t_victim_u();
        logic [31:0] rd, ac; int lat, rds, wrs;
        access(0, 32'h208, 0, 4'b0100, 0, rd, lat, rds, wrs, ac);
        check("R5", "U miss fetches", 32'(rds), 32'd1);
        check("R2", "U miss count 4", ac, 32'd4);
        access(0, 32'h208, 0, 4'b0100, 1, rd, lat, rds, wrs, ac);
        check("R5", "U fill landed in partition 2", 32'(rds), 32'd0);
        check("R5", "data", rd, pat(32'h208));
    endtask

    task automatic t_lru();
        logic [31:0] rd, ac; int lat, rds, wrs;
        for (int k = 1; k <= 4; k++) begin
            access(0, 32'(k*256 + 32'h20), 0, 4'b1111, 0, rd, lat, rds, wrs, ac);
            check("R6", "fill set 1", 32'(rds), 32'd1);
        end
        access(0, 32'h120, 0, 4'b1111, 0, rd, lat, rds, wrs, ac);
        check("R6", "touch oldest line hits", 32'(rds), 32'd0);
        access(0, 32'h520, 0, 4'b1111, 0, rd, lat, rds, wrs, ac);
        check("R6", "fifth line misses", 32'(rds), 32'd1);
        access(0, 32'h520, 0, 4'b0010, 1, rd, lat, rds, wrs, ac);
        check("R6", "LRU victim was partition 1", 32'(rds), 32'd0);
        access(0, 32'h120, 0, 4'b0001, 1, rd, lat, rds, wrs, ac);
        check("R6", "recently touched line kept", 32'(rds), 32'd0);
        access(0, 32'h320, 0, 4'b0100, 1, rd, lat, rds, wrs, ac);
        check("R6", "partition 2 line kept", 32'(rds), 32'd0);
        access(0, 32'h220, 0, 4'b0010, 1, rd, lat, rds, wrs, ac);
        check("R6", "evicted line misses", 32'(rds), 32'd1);
        check("R7", "clean victim no write", 32'(wrs), 32'd0);
    endtask

    task automatic t_writeback();
        logic [31:0] rd, ac; int lat, rds, wrs;
        access(1, 32'h148, 32'hDEAD_BEEF, 4'b0001, 1, rd, lat, rds, wrs, ac);
        check("R8", "store miss allocates", 32'(rds), 32'd1);
        check("R8", "store miss no write", 32'(wrs), 32'd0);
        access(1, 32'h150, 32'h1234_5678, 4'b0001, 1, rd, lat, rds, wrs, ac);
        check("R8", "store hit no traffic", 32'(rds + wrs), 32'd0);
        check("R8", "store hit latency", 32'(lat), 32'd2);
        access(0, 32'h148, 0, 4'b0001, 1, rd, lat, rds, wrs, ac);
        check("R8", "merged word", rd, 32'hDEAD_BEEF);
        access(0, 32'h144, 0, 4'b0001, 1, rd, lat, rds, wrs, ac);
        check("R8", "neighbour word from memory", rd, pat(32'h144));
        access(0, 32'h240, 0, 4'b0001, 1, rd, lat, rds, wrs, ac);
        check("R7", "dirty victim written", 32'(wrs), 32'd1);
        check("R7", "refill read", 32'(rds), 32'd1);
        check("R7", "write first", 32'(log_we[log_n-2]), 32'd1);
        check("R7", "write address", log_addr[log_n-2], 32'h140);
        check("R7", "then read", 32'(log_we[log_n-1]), 32'd0);
        check("R7", "read address", log_addr[log_n-1], 32'h240);
        check("R7", "written word 2", last_wr_data[2*32 +: 32], 32'hDEAD_BEEF);
        check("R7", "written word 4", last_wr_data[4*32 +: 32], 32'h1234_5678);
        check("R7", "written word 0", last_wr_data[31:0], pat(32'h140));
        access(0, 32'h148, 0, 4'b0001, 1, rd, lat, rds, wrs, ac);
        check("R7", "clean victim no write", 32'(wrs), 32'd0);
        check("R8", "reload after write-back", rd, 32'hDEAD_BEEF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        req_mask = '0; req_restrict = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero_mask();
        t_restrict_miss();
        t_victim_u();
        t_lru();
        t_writeback();
        repeat (3) @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule